// File: doc/BRIEF.md
# Multiplexed Address/Data Asynchronous Read Controller

This block is the host side of a single-word read from a memory whose low sixteen address bits and data travel on one shared bus. When the host raises a request, the controller puts the full address out on two sets of lines: the upper address lines, and the shared bus for the low sixteen bits. It drops chip enable and pulses the active-low address-valid strobe for one cycle. The memory takes the address on the rising edge of that strobe. The controller keeps driving the address for one more cycle, then stops driving the shared bus. After one idle gap cycle it lowers output enable.

Output enable stays low for an access window counted in system clock cycles. The window is the largest of three configured delays: address access, chip-enable access and output-enable access. If all three are zero, the window is one cycle. At the clock edge that ends the window, the controller captures the word on the shared bus. It then raises chip enable and output enable and gives a one-cycle done pulse together with the captured word. Write enable is held high and the burst clock is held low at all times.

An active-low reset stops the bus driver and returns the controller to idle. The reset takes effect at once and is released in step with the clock.

Top module: `mux_rd_ctrl`

## Requirements
- R1: While reset is low, the bus driver enable is 0, chip enable, output enable and the address-valid strobe are all 1 (inactive), and done is 0. This holds even if reset arrives in the middle of a read.
- R2: Write enable is 1 and the burst clock output is 0 in every cycle.
- R3: Let E0 be the clock edge at which an idle controller sees the request high. In the cycle after E0, chip enable and the strobe are both 0, the driver enable is 1, the shared bus carries address bits 15..0, and the upper lines carry address bits 23..16.
- R4: In the second cycle after E0, the strobe is 1, giving its rising edge. Chip enable is still 0, output enable is 1, and the same low address is still driven on the bus.
- R5: In the third cycle after E0, the driver enable is 0 and output enable is still 1. Output enable is never 0 in a cycle where the driver enable is 1.
- R6: Output enable is 0 for exactly L cycles, starting in the fourth cycle after E0. L is the largest of the three delay inputs, or 1 if all three are 0. The word on the shared bus at the edge that ends those L cycles is the captured data.
- R7: Done is 1 for exactly one cycle, the cycle after edge E0+3+L. In that cycle the data output holds the captured word, and chip enable and output enable are both 1.
- R8: The address and delay inputs are taken only at E0. A request seen in any cycle other than idle, including the done cycle, is ignored: no new strobe, chip enable or done follows from it.
- R9: After the done cycle the controller is idle. It accepts the next request and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_i | input | 1 | Read request, taken only when idle |
| addr_i | input | 24 | Word address to read |
| t_acc_i | input | 8 | Address access delay in cycles |
| t_ce_i | input | 8 | Chip-enable access delay in cycles |
| t_oe_i | input | 8 | Output-enable access delay in cycles |
| ad_i | input | 16 | Shared bus as seen by the host |
| ad_o | output | 16 | Low address driven onto the shared bus |
| ad_oe_o | output | 1 | Enable of the host driver on the shared bus |
| a_hi_o | output | 8 | Upper address lines |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write enable, held high |
| oe_n_o | output | 1 | Output enable, active low |
| avs_n_o | output | 1 | Address-valid strobe, active low |
| bclk_o | output | 1 | Burst clock, held low |
| rdata_o | output | 16 | Captured read word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives each request half a cycle before the accepting edge and takes that edge as cycle zero. It then checks the pins on the falling edges of cycles one to four: address phase, strobe rise, bus turnaround, and output enable low. The scoreboard records that done is due on the falling edge 4+L cycles after the request was driven, and the monitor compares both that cycle count and the captured word. The bench's memory model puts a wrong word on the bus until the L-th cycle of output enable, so a capture taken one cycle early returns the wrong data. The tests that inject ignored requests during the strobe and done cycles also watch the ports on the following falling edges.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LATCH,
    ST_TURN,
    ST_WAIT,
    ST_DONE
  } mrc_state_e;
endpackage

// File: rtl/mrc_rst_sync.sv
module mrc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/mrc_fsm.sv
module mrc_fsm
  import mrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       hit_i,
  output logic       accept_o,
  output logic       run_o,
  output logic       ad_oe_o,
  output logic       ce_n_o,
  output logic       oe_n_o,
  output logic       avs_n_o,
  output logic       done_o
);
  mrc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_ADDR;
      ST_ADDR:  state_d = ST_LATCH;
      ST_LATCH: state_d = ST_TURN;
      ST_TURN:  state_d = ST_WAIT;
      ST_WAIT:  if (hit_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    accept_o = (state_q == ST_IDLE) && req_i;
    run_o    = (state_q == ST_WAIT);
    ad_oe_o  = (state_q == ST_ADDR) || (state_q == ST_LATCH);
    avs_n_o  = (state_q != ST_ADDR);
    oe_n_o   = (state_q != ST_WAIT);
    ce_n_o   = (state_q == ST_IDLE) || (state_q == ST_DONE);
    done_o   = (state_q == ST_DONE);
  end
endmodule

// File: rtl/mrc_delay.sv
module mrc_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] t_acc_i,
  input  logic [CNT_W-1:0] t_ce_i,
  input  logic [CNT_W-1:0] t_oe_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] m_ab, m_all, lim_d, lim_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    m_ab  = (t_acc_i > t_ce_i) ? t_acc_i : t_ce_i;
    m_all = (m_ab > t_oe_i) ? m_ab : t_oe_i;
    lim_d = (m_all == '0) ? ONE : m_all;
    cnt_d = run_i ? (cnt_q + ONE) : ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= ONE;
    else if (load_i) lim_q <= lim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ONE;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = run_i && (cnt_q == lim_q);
endmodule

// File: rtl/mrc_datapath.sv
module mrc_datapath #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  ad_i,
  output logic [BUS_W-1:0]  ad_o,
  output logic [ADDR_W-BUS_W-1:0] a_hi_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (cap_i) rdata_q <= ad_i;
  end

  assign ad_o    = addr_q[BUS_W-1:0];
  assign a_hi_o  = addr_q[ADDR_W-1:BUS_W];
  assign rdata_o = rdata_q;
endmodule

// File: rtl/mux_rd_ctrl.sv
module mux_rd_ctrl #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16,
  parameter int CNT_W  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [CNT_W-1:0]        t_acc_i,
  input  logic [CNT_W-1:0]        t_ce_i,
  input  logic [CNT_W-1:0]        t_oe_i,
  input  logic [BUS_W-1:0]        ad_i,
  output logic [BUS_W-1:0]        ad_o,
  output logic                    ad_oe_o,
  output logic [ADDR_W-BUS_W-1:0] a_hi_o,
  output logic                    ce_n_o,
  output logic                    we_n_o,
  output logic                    oe_n_o,
  output logic                    avs_n_o,
  output logic                    bclk_o,
  output logic [BUS_W-1:0]        rdata_o,
  output logic                    done_o
);
  logic rst_q_n;
  logic accept, run, hit;

  mrc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  mrc_fsm u_fsm (
    .clk(clk), .rst_n(rst_q_n), .req_i(req_i), .hit_i(hit),
    .accept_o(accept), .run_o(run), .ad_oe_o(ad_oe_o),
    .ce_n_o(ce_n_o), .oe_n_o(oe_n_o), .avs_n_o(avs_n_o), .done_o(done_o)
  );

  mrc_delay #(.CNT_W(CNT_W)) u_dly (
    .clk(clk), .rst_n(rst_q_n), .load_i(accept), .run_i(run),
    .t_acc_i(t_acc_i), .t_ce_i(t_ce_i), .t_oe_i(t_oe_i), .hit_o(hit)
  );

  mrc_datapath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_q_n), .load_i(accept), .cap_i(hit),
    .addr_i(addr_i), .ad_i(ad_i), .ad_o(ad_o), .a_hi_o(a_hi_o),
    .rdata_o(rdata_o)
  );

  assign we_n_o = 1'b1;
  assign bclk_o = 1'b0;
endmodule

// File: rtl/mrc_chk.sv
module mrc_chk (
  input logic clk,
  input logic rst_n,
  input logic ad_oe_o,
  input logic ce_n_o,
  input logic we_n_o,
  input logic oe_n_o,
  input logic avs_n_o,
  input logic bclk_o,
  input logic done_o
);
  AST_WRITE_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) we_n_o && !bclk_o); // R2
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n) !avs_n_o |-> !ce_n_o); // R3
  AST_STROBE_RISE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) ($rose(avs_n_o) && !ce_n_o) |-> (ad_oe_o && oe_n_o)); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) !oe_n_o |-> !ad_oe_o); // R5
  AST_OE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(oe_n_o) |-> $past(!ad_oe_o && avs_n_o && !ce_n_o)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (ce_n_o && oe_n_o)); // R7
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> avs_n_o); // R9
endmodule

bind mux_rd_ctrl mrc_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .ad_oe_o(ad_oe_o), .ce_n_o(ce_n_o),
  .we_n_o(we_n_o), .oe_n_o(oe_n_o), .avs_n_o(avs_n_o), .bclk_o(bclk_o),
  .done_o(done_o)
);

// File: tb/sim_mux_rd_ctrl.sv
`timescale 1ns/1ps
module sim_mux_rd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  t_acc = '0, t_ce = '0, t_oe = '0;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o, rdata;
  logic [7:0]  a_hi;
  logic        ad_oe, ce_n, we_n, oe_n, avs_n, bclk, done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [15:0] data;
    int          due;
  } item_t;
  item_t sb[$];

  logic [23:0] lat_addr = '0;
  int          oe_cnt = 0;
  int          resp_need = 1;
  logic        avs_prev = 1'b1;
  logic        done_prev = 1'b0;

  always #2 clk = ~clk;

  mux_rd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
    .t_acc_i(t_acc), .t_ce_i(t_ce), .t_oe_i(t_oe), .ad_i(ad_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .a_hi_o(a_hi), .ce_n_o(ce_n),
    .we_n_o(we_n), .oe_n_o(oe_n), .avs_n_o(avs_n), .bclk_o(bclk),
    .rdata_o(rdata), .done_o(done)
  );

  function automatic logic [15:0] mem_word(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], a[7:0]} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Responder: latches address on strobe rise, returns valid data only from the L-th OE cycle
  always @(negedge clk) begin
    if (!avs_prev && avs_n && !ce_n) lat_addr = {a_hi, ad_o};
    avs_prev = avs_n;
    if (!oe_n && !ce_n) oe_cnt = oe_cnt + 1;
    else oe_cnt = 0;
    if (!oe_n && !ce_n && oe_cnt >= resp_need) ad_i = mem_word(lat_addr);
    else ad_i = ~mem_word(lat_addr);
  end

  // Monitor: scoreboard pop and pin rules
  always @(negedge clk) begin
    if (rst_n) begin
      chk(we_n == 1'b1 && bclk == 1'b0, "R2 we_n/bclk", {we_n, bclk}, 2'b10);
      chk(!(done && done_prev), "R7 done width", done_prev, 0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(0, "R8 done without accepted request", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(rdata == it.data, "R6 captured word", rdata, it.data);
          chk(cyc == it.due, "R7 done cycle", cyc, it.due);
          chk(ce_n && oe_n, "R7 enables released", {ce_n, oe_n}, 2'b11);
        end
      end
    end
    done_prev = done;
  end

  task automatic do_read(input logic [23:0] a, input int ta, input int tc, input int to, input int inj);
    int lim;
    item_t it;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    lim = ta;
    if (tc > lim) lim = tc;
    if (to > lim) lim = to;
    if (lim == 0) lim = 1;
    resp_need = lim;
    req = 1'b1; addr = a;
    t_acc = 8'(ta); t_ce = 8'(tc); t_oe = 8'(to);
    it.data = mem_word(a);
    it.due  = cyc + 4 + lim;
    sb.push_back(it);
    @(negedge clk);
    req = 1'b0;
    chk(!ce_n && !avs_n && ad_oe, "R3 address phase controls", {ce_n, avs_n, ad_oe}, 3'b001);
    chk(ad_o == a[15:0] && a_hi == a[23:16], "R3/R9 address on pins", {a_hi, ad_o}, a);
    if (inj == 1) begin
      req = 1'b1; addr = ~a; t_oe = 8'd250;
    end
    @(negedge clk);
    req = 1'b0;
    chk(avs_n && !ce_n && oe_n && ad_oe && ad_o == a[15:0], "R4 strobe rise, address held",
        {avs_n, ce_n, oe_n, ad_oe, ad_o}, {4'b1011, a[15:0]});
    @(negedge clk);
    chk(!ad_oe && oe_n && !ce_n, "R5 turnaround gap", {ad_oe, oe_n, ce_n}, 3'b010);
    if (inj == 1) chk(avs_n, "R8 no second strobe", avs_n, 1);
    @(negedge clk);
    chk(!oe_n && !ad_oe, "R6 output enable low", {oe_n, ad_oe}, 2'b00);
    if (inj == 2) begin
      while (!done) @(negedge clk);
      req = 1'b1; addr = ~a;
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i < 8; i++) begin
        chk(ce_n && avs_n, "R8 request in done cycle ignored", {ce_n, avs_n}, 2'b11);
        @(negedge clk);
      end
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(4 * 60000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ad_oe && ce_n && oe_n && avs_n && !done, "R1 reset state",
        {ad_oe, ce_n, oe_n, avs_n, done}, 5'b01110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_n && oe_n && !done, "R1 idle after release", {ce_n, oe_n, done}, 3'b110);

    do_read(24'h12ABCD, 0, 0, 0, 0);
    do_read(24'h345678, 5, 2, 3, 0);
    do_read(24'h00FFFF, 1, 7, 2, 0);
    do_read(24'hA5F00F, 2, 3, 9, 1);
    do_read(24'h7E1234, 3, 3, 3, 2);
    do_read(24'hFF0001, 255, 0, 0, 0);

    // Reset in the middle of an access
    @(negedge clk);
    resp_need = 20;
    req = 1'b1; addr = 24'h0BEEF0; t_acc = 8'd20; t_ce = 8'd0; t_oe = 8'd0;
    @(negedge clk);
    req = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!ad_oe && ce_n && oe_n && avs_n && !done, "R1 reset mid-read",
        {ad_oe, ce_n, oe_n, avs_n, done}, 5'b01110);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_n && !done, "R1 no completion after reset", {ce_n, done}, 2'b10);
    do_read(24'h5A5A5A, 4, 1, 6, 0);
    do_read(24'hC3C3C3, 0, 2, 0, 0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule